// File: doc/BRIEF.md
# Multi-Port Edge-Interrupt GPIO Controller

This block puts up to seven 8-pin GPIO ports behind one simple 32-bit register interface. Each access takes a single cycle. A global control word sits at offset 0x00. It reports how many 8-pin cores are built in and a version number, and it holds two enables: one that switches the whole block on, and one that selects a two-flop input synchronizer instead of a single sampling stage. The registers of each port lie in a window of 0x30 bytes, and port 0 starts at 0x04.

Each port drives its 8 pins in one of four modes: input, push-pull, open-drain or open-source. Each pin also has a pull-up enable. The port watches its pins for a chosen edge per pin and keeps the events it sees in a sticky event register. Software clears an event by writing a 1 to its bit, and it can also set event bits by hand through a force register. Every port drives its own interrupt line. While the block is switched off, the port registers keep their values, no new events are captured and every interrupt line stays low.

Top module: `gpio_mp_top`

## Requirements
- R1: The control word at offset 0x00 returns the port count in bits 15:9 and the parameter VERSION in bits 8:2. Both fields are read-only, and writes to them have no effect.
- R2: Control bit 0 is the block enable and control bit 1 is the synchronizer select. Both are writable and read back, and both are 0 after reset. Writing 0 to the control word switches the block off.
- R3: The registers of port k sit at 0x04 + k*0x30 + word offset. The word offsets are: 0x00 pin level (read-only), 0x04 output value, 0x08 drive mode, 0x0C pull-up enable, 0x10 events, 0x14 interrupt enable, 0x18 event force, 0x1C edge select. Pin p of port k is bit p of that port's 8-bit fields and bit k*8+p of the pin buses.
- R4: Bits 2p+1:2p of the drive-mode register set the mode of pin p. Mode 0 is input (pin_out 0, pin_oe 0). Mode 1 is push-pull (pin_out = value, pin_oe 1). Mode 2 is open-drain (pin_out 0, pin_oe = not value). Mode 3 is open-source (pin_out 1, pin_oe = value).
- R5: An edge-select bit of 1 latches a rising edge of the sampled pin as an event, and a bit of 0 latches a falling edge. An edge of the other polarity is not latched.
- R6: With synchronizer select 1, a pin change shows in the pin-level register two cycles after the pin changes and in the event register three cycles after. With synchronizer select 0, each of these comes one cycle earlier.
- R7: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged.
- R8: Writing a 1 to a bit of the event-force register sets the matching event bit. The force register itself reads back as 0.
- R9: irq[k] is high exactly when the block is enabled and port k has an event bit whose interrupt-enable bit is set.
- R10: While the block is disabled, writes to port registers are ignored, reads of port registers return 0, no events are latched and every irq stays low. The port register values are kept and can be read again once the block is re-enabled.
- R11: Reads of unmapped offsets (port words 0x20 to 0x2C, and any offset at or above 0x04 + NPORTS*0x30) return 0, and writes to them are ignored. Writes to the pin-level register are ignored.
- R12: After reset every port register is 0, so all pins are undriven inputs with pull-ups off and no interrupts.
- R13: pull_en follows the pull-up enable register of each pin, in every drive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| pin_in | input | NPORTS*8 | Pin levels seen from the pads |
| pin_out | output | NPORTS*8 | Pin drive value |
| pin_oe | output | NPORTS*8 | Pin drive enable |
| pull_en | output | NPORTS*8 | Pull-up enable per pin |
| irq | output | NPORTS | One interrupt line per port |

## Verification
The drive logic is tried with all eight pairs of mode and output value on one pin. This separates the four modes from one another, and it separates the open-drain and open-source cases from push-pull, since those two only differ from push-pull in pin_oe or pin_out. A pin on a middle port then checks that the window stride and the bit position within the mode field are decoded correctly. The edge logic is tried with a rising and a falling edge under each synchronizer setting. Sampling one cycle before and at the expected cycle shows both the latency and the polarity filter. A pin toggled while the block is off, and register writes made while it is off, show that disabling the block freezes its state and does not merely hide it.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
   localparam int PINS_PER_PORT = 8;
   localparam int PORT_STRIDE   = 48;   // 0x30 bytes per port window
   localparam int PORT_BASE     = 4;    // first port window offset
   localparam int MAX_PORTS     = 7;

   // word index within a port window
   localparam logic [3:0] W_LEVEL = 4'd0;
   localparam logic [3:0] W_OUT   = 4'd1;
   localparam logic [3:0] W_MODE  = 4'd2;
   localparam logic [3:0] W_PULL  = 4'd3;
   localparam logic [3:0] W_EVT   = 4'd4;
   localparam logic [3:0] W_IEN   = 4'd5;
   localparam logic [3:0] W_FORCE = 4'd6;
   localparam logic [3:0] W_EDGE  = 4'd7;

   typedef enum logic [1:0] {
      DM_INPUT  = 2'd0,
      DM_PUSH   = 2'd1,
      DM_DRAIN  = 2'd2,
      DM_SOURCE = 2'd3
   } drive_mode_e;
endpackage

// File: rtl/gpio_mp_dec.sv
module gpio_mp_dec
   import gpio_mp_pkg::*;
#(
   parameter int NPORTS = 7,
   parameter int ADDR_W = 9,
   parameter int PIDX_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_ctrl,
   output logic              is_port,
   output logic [PIDX_W-1:0] port_idx,
   output logic [3:0]        word
);
   localparam int WIN_END = PORT_BASE + NPORTS * PORT_STRIDE;

   logic [ADDR_W-1:0] wa, off, quo, rem;

   always_comb begin
      wa       = {addr[ADDR_W-1:2], 2'b00};
      off      = wa - ADDR_W'(PORT_BASE);
      quo      = off / ADDR_W'(PORT_STRIDE);
      rem      = off % ADDR_W'(PORT_STRIDE);
      is_ctrl  = (wa == '0);
      is_port  = (wa >= ADDR_W'(PORT_BASE)) && (wa < ADDR_W'(WIN_END));
      port_idx = quo[PIDX_W-1:0];
      word     = rem[5:2];
   end
endmodule

// File: rtl/gpio_mp_ctrl.sv
module gpio_mp_ctrl #(
   parameter int         NPORTS  = 7,
   parameter logic [6:0] VERSION = 7'd5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] rd_data,
   output logic        blk_en,
   output logic        sync_sel
);
   logic [1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 2'b00;
      else if (wr_en) en_q <= wdata[1:0];
   end

   assign blk_en   = en_q[0];
   assign sync_sel = en_q[1];
   assign rd_data  = {16'h0000, 7'(NPORTS), VERSION, en_q};
endmodule

// File: rtl/gpio_mp_port.sv
module gpio_mp_port
   import gpio_mp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        blk_en,
   input  logic        sync_sel,
   input  logic [7:0]  pin_in,
   input  logic        wr_en,
   input  logic [3:0]  word,
   input  logic [31:0] wdata,
   output logic [31:0] rd_data,
   output logic [7:0]  pin_out,
   output logic [7:0]  pin_oe,
   output logic [7:0]  pull_en,
   output logic        irq
);
   logic [7:0]  out_q, pull_q, evt_q, ien_q, edge_q;
   logic [15:0] mode_q;
   logic [7:0]  s1_q, s2_q, prev_q;
   logic [7:0]  smp, hit, evt_nx;

   assign smp = sync_sel ? s2_q : s1_q;
   assign hit = (edge_q & smp & ~prev_q) | (~edge_q & ~smp & prev_q);

   always_comb begin
      evt_nx = evt_q;
      if (wr_en && word == W_EVT)   evt_nx = evt_nx & ~wdata[7:0];
      if (blk_en)                   evt_nx = evt_nx | hit;
      if (wr_en && word == W_FORCE) evt_nx = evt_nx | wdata[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         mode_q <= '0;
         pull_q <= '0;
         evt_q  <= '0;
         ien_q  <= '0;
         edge_q <= '0;
         s1_q   <= '0;
         s2_q   <= '0;
         prev_q <= '0;
      end else begin
         s1_q   <= pin_in;
         s2_q   <= s1_q;
         prev_q <= smp;
         evt_q  <= evt_nx;
         if (wr_en) begin
            case (word)
               W_OUT:   out_q  <= wdata[7:0];
               W_MODE:  mode_q <= wdata[15:0];
               W_PULL:  pull_q <= wdata[7:0];
               W_IEN:   ien_q  <= wdata[7:0];
               W_EDGE:  edge_q <= wdata[7:0];
               default: ;
            endcase
         end
      end
   end

   for (genvar p = 0; p < PINS_PER_PORT; p++) begin : g_drv
      drive_mode_e m;
      assign m = drive_mode_e'(mode_q[2*p +: 2]);
      always_comb begin
         case (m)
            DM_PUSH:   begin pin_out[p] = out_q[p]; pin_oe[p] = 1'b1;      end
            DM_DRAIN:  begin pin_out[p] = 1'b0;     pin_oe[p] = ~out_q[p]; end
            DM_SOURCE: begin pin_out[p] = 1'b1;     pin_oe[p] = out_q[p];  end
            default:   begin pin_out[p] = 1'b0;     pin_oe[p] = 1'b0;      end
         endcase
      end
   end

   always_comb begin
      case (word)
         W_LEVEL: rd_data = {24'h0, smp};
         W_OUT:   rd_data = {24'h0, out_q};
         W_MODE:  rd_data = {16'h0, mode_q};
         W_PULL:  rd_data = {24'h0, pull_q};
         W_EVT:   rd_data = {24'h0, evt_q};
         W_IEN:   rd_data = {24'h0, ien_q};
         W_EDGE:  rd_data = {24'h0, edge_q};
         default: rd_data = '0;
      endcase
   end

   assign pull_en = pull_q;
   assign irq     = blk_en & (|(evt_q & ien_q));
endmodule

// File: rtl/gpio_mp_top.sv
module gpio_mp_top
   import gpio_mp_pkg::*;
#(
   parameter int         NPORTS  = 7,
   parameter logic [6:0] VERSION = 7'd5,
   parameter int         ADDR_W  = 9,
   localparam int        NPINS   = NPORTS * PINS_PER_PORT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pull_en,
   output logic [NPORTS-1:0] irq
);
   localparam int PIDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1;
   localparam int WIN_END = PORT_BASE + NPORTS * PORT_STRIDE;

   if (NPORTS < 1 || NPORTS > MAX_PORTS) begin : g_bad_ports
      $error("NPORTS must be between 1 and 7");
   end
   if ((1 << ADDR_W) <= WIN_END || ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the port windows");
   end

   logic              is_ctrl, is_port, blk_en, sync_sel;
   logic [PIDX_W-1:0] port_idx;
   logic [3:0]        word;
   logic [31:0]       cr_rd, prd_sel;
   logic [31:0]       prd [NPORTS];

   gpio_mp_dec #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) u_dec (
      .addr(bus_addr), .is_ctrl(is_ctrl), .is_port(is_port),
      .port_idx(port_idx), .word(word)
   );

   gpio_mp_ctrl #(.NPORTS(NPORTS), .VERSION(VERSION)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_sel & bus_wr & is_ctrl),
      .wdata(bus_wdata), .rd_data(cr_rd),
      .blk_en(blk_en), .sync_sel(sync_sel)
   );

   for (genvar k = 0; k < NPORTS; k++) begin : g_port
      logic wr_k;
      assign wr_k = bus_sel & bus_wr & is_port & blk_en & (port_idx == PIDX_W'(k));
      gpio_mp_port u_port (
         .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .sync_sel(sync_sel),
         .pin_in(pin_in[k*PINS_PER_PORT +: PINS_PER_PORT]),
         .wr_en(wr_k), .word(word), .wdata(bus_wdata), .rd_data(prd[k]),
         .pin_out(pin_out[k*PINS_PER_PORT +: PINS_PER_PORT]),
         .pin_oe(pin_oe[k*PINS_PER_PORT +: PINS_PER_PORT]),
         .pull_en(pull_en[k*PINS_PER_PORT +: PINS_PER_PORT]),
         .irq(irq[k])
      );
   end

   always_comb begin
      prd_sel = '0;
      for (int k = 0; k < NPORTS; k++)
         if (port_idx == PIDX_W'(k)) prd_sel = prd[k];
   end

   always_comb begin
      if (!bus_sel)                 bus_rdata = '0;
      else if (is_ctrl)             bus_rdata = cr_rd;
      else if (is_port && blk_en)   bus_rdata = prd_sel;
      else                          bus_rdata = '0;
   end
endmodule

// File: rtl/gpio_mp_chk.sv
module gpio_mp_chk #(
   parameter int         NPORTS  = 7,
   parameter logic [6:0] VERSION = 7'd5,
   parameter int         ADDR_W  = 9,
   localparam int        NPINS   = NPORTS * 8,
   localparam int        WIN_END = 4 + NPORTS * 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPORTS-1:0] irq,
   input logic              blk_en
);
   // R1: identity fields of the control word
   a_r1_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[ADDR_W-1:2] == '0) |->
      (bus_rdata[15:9] == 7'(NPORTS) && bus_rdata[8:2] == VERSION));

   // R10: no interrupt while the block is off
   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en |-> (irq == '0));

   // R10: pad drive frozen while the block stays off
   a_r10_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_en && !$past(blk_en)) |-> ($stable(pin_out) && $stable(pin_oe)));

   // R11: reads past the last port window return zero
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr >= ADDR_W'(WIN_END)) |-> (bus_rdata == '0));

   // R9: a new interrupt appears only with the block enabled
   a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq & ~$past(irq))) |-> blk_en);
endmodule

bind gpio_mp_top gpio_mp_chk #(.NPORTS(NPORTS), .VERSION(VERSION), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_out(pin_out),
   .pin_oe(pin_oe), .irq(irq), .blk_en(blk_en)
);

// File: tb/tb_gpio_mp_top.sv
`timescale 1ns/1ps
module tb_gpio_mp_top;
   localparam int NP = 7;
   localparam int AW = 9;
   localparam logic [31:0] CR_RO = 32'h0000_0E14; // 7<<9 | 5<<2

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic [NP*8-1:0] pin_in = '0, pin_out, pin_oe, pull_en;
   logic [NP-1:0] irq;

   int n_tests = 0, n_fail = 0;

   always #5 clk = ~clk;

   gpio_mp_top #(.NPORTS(NP), .VERSION(7'd5), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pull_en(pull_en), .irq(irq)
   );

   // {mode[1:0], value, exp_out, exp_oe}
   localparam logic [4:0] DRV_TBL [8] = '{
      5'b00_0_0_0, 5'b00_1_0_0, 5'b01_0_0_1, 5'b01_1_1_1,
      5'b10_0_0_1, 5'b10_1_0_0, 5'b11_0_1_0, 5'b11_1_1_1 };

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      tick();
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int pa(int k, int w);
      return 4 + k*48 + w;
   endfunction

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1'b1;
      tick();

      // R12 reset state
      chk("R12 oe", 32'(pin_oe[31:0]), 0);
      chk("R12 irq", 32'(irq), 0);
      rd(0, d); chk("R1 R12 ctrl reset", d, CR_RO);

      // R10 write while disabled is dropped
      wr(pa(0, 'h04), 32'hFF);
      wr(0, 1);
      rd(pa(0, 'h04), d); chk("R10 write while off", d, 0);

      // R1/R2 control read-only fields
      wr(0, 32'hFFFF_FFFF);
      rd(0, d); chk("R1 R2 ctrl write", d, CR_RO | 32'h3);
      wr(0, 1);

      // R4 drive table on port 0 pin 0
      for (int i = 0; i < 8; i++) begin
         wr(pa(0, 'h08), 32'(DRV_TBL[i][4:3]));
         wr(pa(0, 'h04), 32'(DRV_TBL[i][2]));
         chk($sformatf("R4 out vec%0d", i), 32'(pin_out[0]), 32'(DRV_TBL[i][1]));
         chk($sformatf("R4 oe vec%0d", i), 32'(pin_oe[0]), 32'(DRV_TBL[i][0]));
      end

      // R3 window stride: port 3 pin 5 push-pull high
      wr(pa(3, 'h08), 32'h0400);
      wr(pa(3, 'h04), 32'h20);
      chk("R3 port3 pin5 out", 32'(pin_out[29]), 1);
      chk("R3 port3 pin5 oe", 32'(pin_oe[29]), 1);
      rd(pa(3, 'h08), d); chk("R3 mode readback", d, 32'h0400);

      // R13 pull-ups
      wr(pa(0, 'h0C), 32'hA5);
      chk("R13 pull_en", 32'(pull_en[7:0]), 32'hA5);

      // R5 R6 rising edge with synchronizer (port 2, pin 1 = bit 17)
      wr(0, 3);
      wr(pa(2, 'h1C), 32'h02);
      wr(pa(2, 'h14), 32'h02);
      pin_in[17] = 1'b1;
      tick(2);
      rd(pa(2, 'h10), d); chk("R6 sync no evt at 2", d, 0);
      rd(pa(2, 'h00), d); chk("R6 sync level at 2", d, 32'h02);
      tick();
      rd(pa(2, 'h10), d); chk("R5 R6 rise evt at 3", d, 32'h02);
      chk("R9 irq port2", 32'(irq), 32'h04);

      // R7 write-1-clear
      wr(pa(2, 'h10), 32'h00);
      rd(pa(2, 'h10), d); chk("R7 write0 keeps", d, 32'h02);
      wr(pa(2, 'h10), 32'h02);
      rd(pa(2, 'h10), d); chk("R7 write1 clears", d, 0);
      chk("R9 irq cleared", 32'(irq), 0);

      // R5 R6 falling edge without synchronizer
      wr(0, 1);
      wr(pa(2, 'h1C), 32'h00);
      pin_in[17] = 1'b0;
      tick();
      rd(pa(2, 'h10), d); chk("R6 nosync no evt at 1", d, 0);
      tick();
      rd(pa(2, 'h10), d); chk("R5 R6 fall evt at 2", d, 32'h02);
      wr(pa(2, 'h10), 32'h02);
      pin_in[17] = 1'b1;
      tick(4);
      rd(pa(2, 'h10), d); chk("R5 rise ignored on falling", d, 0);

      // R8 force, R9 masking
      wr(pa(2, 'h18), 32'h80);
      rd(pa(2, 'h10), d); chk("R8 force sets", d, 32'h80);
      rd(pa(2, 'h18), d); chk("R8 force reads 0", d, 0);
      chk("R9 masked", 32'(irq), 0);
      wr(pa(2, 'h14), 32'h80);
      chk("R9 unmasked", 32'(irq), 32'h04);

      // R10 disable freezes and hides
      wr(0, 0);
      chk("R10 irq off", 32'(irq), 0);
      rd(pa(2, 'h10), d); chk("R10 read off", d, 0);
      wr(pa(3, 'h04), 32'h00);
      chk("R10 pin held", 32'(pin_out[29]), 1);
      pin_in[17] = 1'b0;
      tick(4);
      wr(0, 1);
      rd(pa(2, 'h10), d); chk("R10 evt kept, none new", d, 32'h80);
      rd(pa(3, 'h04), d); chk("R10 out kept", d, 32'h20);
      chk("R10 irq back", 32'(irq), 32'h04);

      // R11 unmapped and read-only
      wr(pa(0, 'h20), 32'hFFFF);
      rd(pa(0, 'h20), d); chk("R11 hole", d, 0);
      rd(4 + NP*48, d); chk("R11 past end", d, 0);
      wr(pa(2, 'h00), 32'hFF);
      rd(pa(2, 'h00), d); chk("R11 level ro", d, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule